// File: doc/BRIEF.md
# Bit-Field Extractor

This combinational unit pulls a contiguous bit field out of a container word and returns it right-justified. The result is either zero-extended or sign-extended, depending on a signed-mode input. The container is `DATA_W` bits wide, 64 by default.

A single control word says where the field starts and how long it is:

- The low bits of the control word carry the bit offset.
- The upper half of the control word carries the field length.
- The two sub-fields are far apart, so software can pack them with plain OR and shift operations.

A length code of zero is treated as a full-width field. So is a code equal to `DATA_W`, and so is any larger code. With a full-width field, the unit degenerates into an ordinary right shift: logical in unsigned mode and arithmetic in signed mode. One unit therefore serves shifts and extracts alike.

Internally there is exactly one right shifter, a logarithmic network with one mux stage per offset bit. The field mask comes from a greater-than decoder on the effective length, not from a second shifter. A field that would run past the top of the container is cut off at the most significant bit. In that case its sign is taken from that bit.

Top module: `fx_extract_unit`

## Requirements
- R1: The offset is control bits `[OFF_W-1:0]` with `OFF_W = log2(DATA_W)` (bits 5:0 at 64). The field's least significant bit is container bit `offset`, and it appears at result bit 0.
- R2: The length code is control bits `[DATA_W/2 + OFF_W : DATA_W/2]` (bits 38:32 at 64). Codes 1 to `DATA_W-1` select that many bits. Codes 0, `DATA_W` and anything above `DATA_W` all select a full-width field.
- R3: Every control bit outside the offset and length fields has no effect on the result.
- R4: In unsigned mode (`isSigned` = 0), result bits above the effective field length are zero. The field bits equal the container bits starting at the offset.
- R5: In signed mode (`isSigned` = 1), every result bit above the effective field equals the field's most significant bit.
- R6: When offset plus length exceeds `DATA_W`, the field is truncated to end at container bit `DATA_W-1`. Its sign bit is then container bit `DATA_W-1`.
- R7: With a full-width field, the result is the container shifted right by the offset: logical in unsigned mode, arithmetic in signed mode.
- R8: The result is a pure combinational function of the present inputs, with no clock and no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | DATA_W | Container word holding the field |
| ctl | input | DATA_W | Packed control word: offset in the low bits, length code in the upper half |
| isSigned | input | 1 | 1 = sign-extend the field, 0 = zero-extend |
| dout | output | DATA_W | Right-justified extracted field |

## Verification
The bench builds two copies of the unit. The first uses `DATA_W = 16`. At that size, all 16 offsets and all 32 values of the 5-bit length code can be swept in both modes over several container patterns. This exhaustive sweep reaches every truncation boundary, every out-of-range length alias and every sign-fill position. The second copy keeps the default 64-bit width. It is driven with randomized offsets, length codes and filler bits, plus hand-picked corners around offset 63, code 0 and codes 64 and 65. Expected values come from a double-shift formula: shift the field to the top of a 64-bit word, then shift it back down logically or arithmetically.

// File: rtl/fx_pkg.sv
package fx_pkg;
  typedef struct packed {
    logic fullWidth;   // length code aliases to whole container
    logic truncTop;    // field clipped at the container MSB
    logic fillSign;    // replicate field MSB above the field
  } fx_strobe_t;
endpackage

// File: rtl/fx_ctrl.sv
module fx_ctrl
  import fx_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int OFF_W = $clog2(DATA_W),
  localparam int LEN_W = OFF_W + 1
) (
  input  logic [OFF_W-1:0] offIn,
  input  logic [LEN_W-1:0] lenCode,
  input  logic             isSigned,
  output fx_strobe_t       strobe,
  output logic [LEN_W-1:0] effLen
);
  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(DATA_W);

  logic [LEN_W-1:0] reqLen;
  logic [LEN_W-1:0] availLen;

  always_comb begin
    strobe.fullWidth = (lenCode == '0) || (lenCode >= FULL_LEN);
    reqLen           = strobe.fullWidth ? FULL_LEN : lenCode;
    availLen         = FULL_LEN - {1'b0, offIn};
    strobe.truncTop  = reqLen >= availLen;
    strobe.fillSign  = isSigned;
    effLen           = strobe.truncTop ? availLen : reqLen;
  end
endmodule

// File: rtl/fx_maskgen.sv
module fx_maskgen #(
  parameter int DATA_W = 64,
  localparam int LEN_W = $clog2(DATA_W) + 1
) (
  input  logic [LEN_W-1:0]  effLen,
  output logic [DATA_W-1:0] fieldMask
);
  // greater-than decoder: bit i is kept while i < effLen
  for (genvar i = 0; i < DATA_W; i++) begin : g_cmp
    assign fieldMask[i] = LEN_W'(i) < effLen;
  end
endmodule

// File: rtl/fx_datapath.sv
module fx_datapath
  import fx_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int OFF_W = $clog2(DATA_W),
  localparam int LEN_W = OFF_W + 1
) (
  input  logic [DATA_W-1:0] din,
  input  logic [OFF_W-1:0]  offIn,
  input  logic [LEN_W-1:0]  effLen,
  input  fx_strobe_t        strobe,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] stage [OFF_W+1];
  logic [DATA_W-1:0] fieldMask;
  logic [OFF_W-1:0]  topIdx;
  logic              signBit;
  logic              unusedStrobe;

  assign stage[0] = din;
  for (genvar s = 0; s < OFF_W; s++) begin : g_shift
    assign stage[s+1] = offIn[s] ? (stage[s] >> (1 << s)) : stage[s];
  end

  fx_maskgen #(.DATA_W(DATA_W)) u_mask (
    .effLen   (effLen),
    .fieldMask(fieldMask)
  );

  assign topIdx       = OFF_W'(effLen - LEN_W'(1));
  assign signBit      = stage[OFF_W][topIdx];
  assign unusedStrobe = strobe.fullWidth ^ strobe.truncTop;

  assign dout = (stage[OFF_W] & fieldMask)
              | ((strobe.fillSign && signBit) ? ~fieldMask : '0);
endmodule

// File: rtl/fx_extract_unit.sv
module fx_extract_unit
  import fx_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] ctl,
  input  logic              isSigned,
  output logic [DATA_W-1:0] dout
);
  localparam int OFF_W = $clog2(DATA_W);
  localparam int LEN_W = OFF_W + 1;
  localparam int LEN_LO = DATA_W / 2;

  fx_strobe_t       strobe;
  logic [LEN_W-1:0] effLen;
  logic             unusedCtl;

  assign unusedCtl = ^ctl;

  fx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .offIn   (ctl[OFF_W-1:0]),
    .lenCode (ctl[LEN_LO +: LEN_W]),
    .isSigned(isSigned),
    .strobe  (strobe),
    .effLen  (effLen)
  );

  fx_datapath #(.DATA_W(DATA_W)) u_dp (
    .din   (din),
    .offIn (ctl[OFF_W-1:0]),
    .effLen(effLen),
    .strobe(strobe),
    .dout  (dout)
  );
endmodule

// File: rtl/fx_extract_unit_chk.sv
module fx_extract_unit_chk #(
  parameter int DATA_W = 64
) (
  input logic [DATA_W-1:0] din,
  input logic [DATA_W-1:0] ctl,
  input logic              isSigned,
  input logic [DATA_W-1:0] dout
);
  localparam int OFF_W = $clog2(DATA_W);
  localparam int LEN_W = OFF_W + 1;

  int offI, codeI, wI, effI;
  logic unusedCtlChk;
  logic signed [DATA_W-1:0] upper;

  assign unusedCtlChk = ^ctl;
  assign offI  = int'(ctl[OFF_W-1:0]);
  assign codeI = int'(ctl[DATA_W/2 +: LEN_W]);
  assign wI    = (codeI == 0 || codeI >= DATA_W) ? DATA_W : codeI;
  assign effI  = (wI < DATA_W - offI) ? wI : DATA_W - offI;
  assign upper = $signed(dout) >>> (effI - 1);

  always_comb begin
    if (!isSigned) begin
      a_r4_within_source: assert ((dout & ~(din >> offI)) == '0);
      a_r4_zero_above: assert ((dout >> effI) == '0);
    end
    if (isSigned) begin
      a_r5_sign_fill: assert (upper == '0 || upper == '1);
    end
    if (wI == DATA_W && !isSigned) begin
      a_r7_logical: assert (dout == (din >> offI));
    end
    if (wI == DATA_W && isSigned) begin
      a_r7_arith: assert (dout == DATA_W'($signed(din) >>> offI));
    end
    if (effI < wI && !isSigned) begin
      a_r6_trunc_top: assert (dout == (din >> offI));
    end
  end
endmodule

bind fx_extract_unit fx_extract_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .din(din), .ctl(ctl), .isSigned(isSigned), .dout(dout)
);

// File: tb/fx_extract_unit_test.sv
module fx_extract_unit_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int checks = 0;
  int errs = 0;
  int cycles = 0;
  bit done = 0;

  logic [15:0] nDin, nCtl, nOut;
  logic        nSgn;
  logic [63:0] wDin, wCtl, wOut;
  logic        wSgn;

  fx_extract_unit #(.DATA_W(16)) uut (
    .din(nDin), .ctl(nCtl), .isSigned(nSgn), .dout(nOut)
  );
  fx_extract_unit #(.DATA_W(64)) uutWide (
    .din(wDin), .ctl(wCtl), .isSigned(wSgn), .dout(wOut)
  );

  // reference from the requirements: decode, then double shift
  function automatic logic [63:0] refCalc(input int dw, input logic [63:0] d,
                                          input logic [63:0] c, input bit s);
    int offW = $clog2(dw);
    int off  = int'(c & ((64'd1 << offW) - 1));
    int code = int'((c >> (dw / 2)) & ((64'd1 << (offW + 1)) - 1));
    int w    = (code == 0 || code >= dw) ? dw : code;
    int eff  = (w < dw - off) ? w : dw - off;
    logic [63:0] t = d << (64 - off - eff);
    logic [63:0] r = s ? 64'($signed(t) >>> (64 - eff)) : (t >> (64 - eff));
    if (dw < 64) r = r & ((64'd1 << dw) - 1);
    return r;
  endfunction

  function automatic string tagOf(input int dw, input logic [63:0] c, input bit s);
    int offW = $clog2(dw);
    int off  = int'(c & ((64'd1 << offW) - 1));
    int code = int'((c >> (dw / 2)) & ((64'd1 << (offW + 1)) - 1));
    int w    = (code == 0 || code >= dw) ? dw : code;
    if (w == dw) return "R7";
    if (w > dw - off) return "R6";
    return s ? "R5" : "R4";
  endfunction

  task automatic compare(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runN(input logic [15:0] d, input logic [15:0] c, input bit s, input string tag);
    @(negedge clk);
    nDin = d; nCtl = c; nSgn = s;
    @(posedge clk); #1;
    compare(tag, {48'd0, nOut}, refCalc(16, {48'd0, d}, {48'd0, c}, s));
  endtask

  task automatic runW(input logic [63:0] d, input logic [63:0] c, input bit s, input string tag);
    @(negedge clk);
    wDin = d; wCtl = c; wSgn = s;
    @(posedge clk); #1;
    compare(tag, wOut, refCalc(64, d, c, s));
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!done && cycles > 150000) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] pats [4] = '{16'hA5C3, 16'h5A3C, 16'hFFFF, 16'h8001};
    nDin = '0; nCtl = '0; nSgn = 0;
    wDin = '0; wCtl = '0; wSgn = 0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #1;
    compare("R4 idle zero", {48'd0, nOut}, 64'd0);

    // R1 offset / R2 length targeted cases on the narrow copy
    runN(16'hABCD, {3'b0, 5'd4, 4'b0, 4'd4}, 0, "R1");   // expect 0xC
    compare("R1 literal", {48'd0, nOut}, 64'h000C);
    runN(16'h1234, {3'b0, 5'd0, 4'b0, 4'd0}, 0, "R2");   // code 0 = whole word
    compare("R2 code0 literal", {48'd0, nOut}, 64'h1234);
    runN(16'h1234, {3'b0, 5'd20, 4'b0, 4'd0}, 0, "R2");  // code above width
    compare("R2 code20 literal", {48'd0, nOut}, 64'h1234);

    // exhaustive narrow sweep
    for (int p = 0; p < 4; p++)
      for (int o = 0; o < 16; o++)
        for (int code = 0; code < 32; code++)
          for (int s = 0; s < 2; s++) begin
            logic [15:0] c;
            c = {3'($urandom), 5'(code), 4'($urandom), 4'(o)};
            runN(pats[p], c, bit'(s), tagOf(16, {48'd0, c}, bit'(s)));
          end

    // R3: filler bits all zero vs all one give identical output
    for (int o = 0; o < 16; o += 3) begin
      logic [15:0] keep;
      runN(16'hC3A5, {3'b000, 5'd5, 4'h0, 4'(o)}, 1, "R3");
      keep = nOut;
      runN(16'hC3A5, {3'b111, 5'd5, 4'hF, 4'(o)}, 1, "R3");
      compare("R3 filler ignored", {48'd0, nOut}, {48'd0, keep});
    end

    // R8: output follows an input change without any clock edge
    @(negedge clk);
    nDin = 16'h00F0; nCtl = {3'b0, 5'd4, 4'b0, 4'd4}; nSgn = 1;
    #1 compare("R8 first", {48'd0, nOut}, 64'hFFFF);
    nDin = 16'h0070;
    #1 compare("R8 second", {48'd0, nOut}, 64'h0007);

    // wide corners
    runW(64'h8000_0000_0000_0000, {25'd0, 7'd0, 26'd0, 6'd63}, 1, "R7");
    compare("R7 arith literal", wOut, 64'hFFFF_FFFF_FFFF_FFFF);
    runW(64'h8000_0000_0000_0000, {25'd0, 7'd64, 26'd0, 6'd63}, 0, "R7");
    runW(64'hF0F0_0000_0000_0001, {25'd0, 7'd65, 26'd0, 6'd0}, 1, "R2");
    runW(64'hDEAD_BEEF_0123_4567, {25'd0, 7'd16, 26'd0, 6'd56}, 1, "R6");
    compare("R6 literal", wOut, 64'hFFFF_FFFF_FFFF_FFDE);
    runW(64'h0000_0000_0000_8000, {25'd0, 7'd16, 26'd0, 6'd0}, 1, "R5");
    compare("R5 literal", wOut, 64'hFFFF_FFFF_FFFF_8000);
    runW(64'h0000_0000_0000_8000, {25'd0, 7'd16, 26'd0, 6'd0}, 0, "R4");
    compare("R4 literal", wOut, 64'h0000_0000_0000_8000);

    // wide random
    for (int i = 0; i < 1500; i++) begin
      logic [63:0] d, c;
      bit s;
      d = {$urandom, $urandom};
      c = {$urandom, $urandom};
      s = bit'($urandom);
      runW(d, c, s, tagOf(64, c, s));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule